// File: doc/BRIEF.md
# Condition Register File with Nibble Forwarding

This block keeps a processor's condition register as one wide word divided into 4-bit fields. A single read port always returns the whole word. Writers present a per-nibble enable mask together with a full-width data word, and only the nibbles whose enable bit is set take new values. When a write arrives in the same cycle as a read, the read result already holds the merged value. The enabled nibbles come from the write data and the rest come from the stored word, so a consumer in the same cycle never sees stale fields.

Two write request ports exist: port A and port B. Only one condition-register write is legal per cycle. If both ports present a non-zero mask in the same cycle, port A's write is used, port B's write is dropped, and a collision flag is raised in the following cycle.

The ports carry a new value every cycle with no flow control. Reads and writes are per-cycle register-file accesses, so there is no valid/ready handshake and no back-pressure. A request is simply "mask non-zero".

Top module: `cond_reg_file`

## Requirements
- R1: A synchronous reset clears the stored register to zero. The collision flag is also cleared. In the first cycle after reset, with no write, `rd_data` reads 0.
- R2: In a cycle where the selected write has mask bit i set, nibble i of `rd_data` (bits 4i+3..4i) equals nibble i of that write's data in the same cycle.
- R3: After a clock edge, every nibble that was written in the previous cycle reads back the written value. This holds while no new write is presented.
- R4: Nibbles whose mask bit is clear keep their previous stored value. They appear unchanged on `rd_data` both in the cycle of the write and afterwards.
- R5: A mask of all zeros on both ports leaves the register unchanged, and `rd_data` stays stable.
- R6: `collision` is 1 in the cycle after both `wa_mask` and `wb_mask` are non-zero, and 0 in the cycle after any other combination.
- R7: When both ports request in the same cycle, only port A's masked nibbles are forwarded and stored. Port B's data has no effect.
- R8: A write on port B alone, with `wa_mask` zero, is forwarded and stored like a port A write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wa_mask | input | 8 | Port A nibble enables, bit i selects bits 4i+3..4i |
| wa_data | input | 32 | Port A write data |
| wb_mask | input | 8 | Port B nibble enables |
| wb_data | input | 32 | Port B write data |
| rd_data | output | 32 | Stored word merged with the selected same-cycle write |
| collision | output | 1 | High one cycle after both ports requested together |

## Verification
The assertions watch four things on every cycle:
- the register holds still across idle cycles;
- nibbles written on port A land in storage;
- unmasked nibbles survive a write;
- the collision flag follows the pair of request masks one cycle later.

Only the bench's scenarios can show the exact forwarded value within the cycle. The bench sweeps every mask on each port, compares against arithmetic merges, and runs collision pairs in which port B's data must leave no trace.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int CR_WIDTH_DEF = 32;
  localparam int CR_NIB_DEF   = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } cr_src_e;
endpackage

// File: rtl/cr_write_select.sv
module cr_write_select
  import cr_pkg::*;
#(
  parameter int WIDTH = CR_WIDTH_DEF,
  parameter int NIB   = CR_NIB_DEF,
  localparam int NUM  = WIDTH / NIB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   a_mask,
  input  logic [WIDTH-1:0] a_data,
  input  logic [NUM-1:0]   b_mask,
  input  logic [WIDTH-1:0] b_data,
  output logic [NUM-1:0]   sel_mask,
  output logic [WIDTH-1:0] sel_data,
  output logic             clash_q
);
  cr_src_e src;
  logic    a_req, b_req;

  assign a_req = |a_mask;
  assign b_req = |b_mask;

  always_comb begin
    if (a_req)      src = SRC_A;
    else if (b_req) src = SRC_B;
    else            src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_A:   begin sel_mask = a_mask; sel_data = a_data; end
      SRC_B:   begin sel_mask = b_mask; sel_data = b_data; end
      default: begin sel_mask = '0;     sel_data = '0;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) clash_q <= 1'b0;
    else     clash_q <= a_req & b_req;
  end
endmodule

// File: rtl/cr_nibble_merge.sv
module cr_nibble_merge
  import cr_pkg::*;
#(
  parameter int WIDTH = CR_WIDTH_DEF,
  parameter int NIB   = CR_NIB_DEF,
  localparam int NUM  = WIDTH / NIB
) (
  input  logic [WIDTH-1:0] base,
  input  logic [WIDTH-1:0] wdata,
  input  logic [NUM-1:0]   mask,
  output logic [WIDTH-1:0] merged
);
  for (genvar g = 0; g < NUM; g++) begin : g_nib
    assign merged[g*NIB +: NIB] = mask[g] ? wdata[g*NIB +: NIB] : base[g*NIB +: NIB];
  end
endmodule

// File: rtl/cr_store.sv
module cr_store
  import cr_pkg::*;
#(
  parameter int WIDTH = CR_WIDTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/cond_reg_file.sv
module cond_reg_file
  import cr_pkg::*;
#(
  parameter int WIDTH = CR_WIDTH_DEF,
  parameter int NIB   = CR_NIB_DEF,
  localparam int NUM  = WIDTH / NIB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   wa_mask,
  input  logic [WIDTH-1:0] wa_data,
  input  logic [NUM-1:0]   wb_mask,
  input  logic [WIDTH-1:0] wb_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             collision
);
  logic [NUM-1:0]   sel_mask;
  logic [WIDTH-1:0] sel_data;
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] merged;

  cr_write_select #(.WIDTH(WIDTH), .NIB(NIB)) sel_i (
    .clk(clk), .rst(rst),
    .a_mask(wa_mask), .a_data(wa_data),
    .b_mask(wb_mask), .b_data(wb_data),
    .sel_mask(sel_mask), .sel_data(sel_data),
    .clash_q(collision)
  );

  cr_nibble_merge #(.WIDTH(WIDTH), .NIB(NIB)) merge_i (
    .base(stored), .wdata(sel_data), .mask(sel_mask), .merged(merged)
  );

  cr_store #(.WIDTH(WIDTH)) store_i (
    .clk(clk), .rst(rst), .d(merged), .q(stored)
  );

  assign rd_data = merged;

  // Bit-level views of the nibble masks, used by the checks below
  logic [WIDTH-1:0] a_bits, sel_bits;
  logic             any_req;
  for (genvar g = 0; g < NUM; g++) begin : g_bits
    assign a_bits[g*NIB +: NIB]   = {NIB{wa_mask[g]}};
    assign sel_bits[g*NIB +: NIB] = {NIB{sel_mask[g]}};
  end
  assign any_req = (|wa_mask) | (|wb_mask);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst ##1 (!rst && !any_req) |-> (rd_data == '0));

  assert_a_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (|wa_mask) ##1 (!any_req) |-> ((rd_data & $past(a_bits)) == ($past(wa_data) & $past(a_bits))));

  assert_unmasked_kept_R4: assert property (@(posedge clk) disable iff (rst)
    any_req ##1 (!any_req) |-> ((rd_data & ~$past(sel_bits)) == ($past(rd_data) & ~$past(sel_bits))));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!any_req) ##1 (!any_req) |-> $stable(rd_data));

  assert_clash_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ((|wa_mask) && (|wb_mask)) |=> collision);

  assert_clash_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !((|wa_mask) && (|wb_mask)) |=> !collision);
endmodule

// File: tb/cond_reg_file_tb_top.sv
module cond_reg_file_tb_top;
  localparam int W = 32;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] wa_mask = '0, wb_mask = '0;
  logic [W-1:0] wa_data = '0, wb_data = '0;
  logic [W-1:0] rd_data;
  logic         collision;

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] ref_q = '0;
  logic         ref_coll = 1'b0;

  always #10 clk = ~clk;

  cond_reg_file dut_i (
    .clk(clk), .rst(rst),
    .wa_mask(wa_mask), .wa_data(wa_data),
    .wb_mask(wb_mask), .wb_data(wb_data),
    .rd_data(rd_data), .collision(collision)
  );

  function automatic logic [W-1:0] mix(logic [W-1:0] b, logic [W-1:0] d, logic [N-1:0] m);
    logic [W-1:0] r;
    r = b;
    for (int i = 0; i < N; i++)
      if (m[i]) r[i*4 +: 4] = d[i*4 +: 4];
    return r;
  endfunction

  task automatic check32(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Drive one cycle; check the flag from the previous cycle and the forwarded read
  task automatic step(string tag, logic [N-1:0] ma, logic [W-1:0] da,
                      logic [N-1:0] mb, logic [W-1:0] db);
    logic [W-1:0] exp;
    @(negedge clk);
    check1("R6 collision", collision, ref_coll);
    wa_mask = ma; wa_data = da; wb_mask = mb; wb_data = db;
    #1;
    if (ma != 0)      exp = mix(ref_q, da, ma);
    else if (mb != 0) exp = mix(ref_q, db, mb);
    else              exp = ref_q;
    check32(tag, rd_data, exp);
    @(posedge clk);
    ref_q    = exp;
    ref_coll = (ma != 0) && (mb != 0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check32("R1 reset value", rd_data, '0);
    check1("R1 collision after reset", collision, 1'b0);

    // Idle: nothing changes (R5)
    for (int k = 0; k < 4; k++) step("R5 idle", '0, 32'hFFFF_FFFF, '0, 32'hFFFF_FFFF);

    // Port A alone, every mask (R2, R3, R4)
    for (int m = 0; m < 256; m++) begin
      v = 32'h1234_5678 ^ (m * 32'h9E37_79B9);
      step("R2 port A forward", m[N-1:0], v, '0, '0);
      step("R3 R4 port A stored", '0, '0, '0, '0);
    end

    // Port B alone, every mask (R8)
    for (int m = 0; m < 256; m++) begin
      v = 32'hCAFE_F00D + (m * 32'h0101_0101);
      step("R8 port B forward", '0, '0, m[N-1:0], v);
      step("R8 port B stored", '0, '0, '0, '0);
    end

    // Collisions: port A wins, port B dropped (R6, R7)
    for (int i = 1; i < 256; i += 17) begin
      for (int j = 1; j < 256; j += 23) begin
        v = 32'hA5A5_0000 | (i << 8) | j;
        step("R7 collision forward", i[N-1:0], v, j[N-1:0], ~v);
        step("R7 collision stored", '0, '0, '0, '0);
      end
    end

    // Back-to-back collision then single write (R6 flag pattern)
    step("R6 clash", 8'h01, 32'h1, 8'h80, 32'h0);
    step("R6 clash again", 8'hF0, 32'h8765_4321, 8'h0F, 32'h0);
    step("R6 single", 8'hFF, 32'h0, 8'h00, 32'h0);
    step("R6 idle", '0, '0, '0, '0);
    @(negedge clk);
    check1("R6 final collision", collision, ref_coll);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule